// File: doc/BRIEF.md
# Pipeline Hazard and Branch Control Unit

This unit steers a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It looks at the register numbers held in the decode, execute, memory and writeback stages, at the load and branch flags, and at the branch condition computed in execute. From these it picks the bypass source for each execute operand, holds decode for one cycle when a value is still being loaded, and steers the program counter. The ALU, register file and memories sit outside the unit.

Every branch is assumed taken. When a branch reaches decode, the unit loads its target into the PC. The instruction fetched just behind the branch is its delay slot, and that instruction always runs. The branch resolves in execute. If it turns out not taken, the one wrong-path instruction being fetched at that moment is squashed, and fetch resumes at the branch address plus 8. A branch whose target already equals its address plus 8 needs no repair.

The controls are combinational, so the datapath can use them in the same cycle. The register file is taken to write in the first half of a cycle and read in the second, so decode never needs a bypass from writeback.

Top module: `hz_ctl_top`

## Requirements
- R1: An execute operand whose source register is nonzero and equals the memory-stage destination, with memory-stage write enabled, selects the memory bypass (code 2'b10). This holds even when writeback also matches.
- R2: An operand with no memory-stage match, but whose nonzero source equals the writeback destination with writeback write enabled, selects the writeback bypass (code 2'b01).
- R3: Register 0 is never bypassed. A source of 0 always selects the register file (code 2'b00).
- R4: A load-use hazard exists when execute holds a load with a nonzero destination and decode uses that register as either source. Decode may hold a branch comparing that register. During the hazard, stall and idex_bubble are 1 and ifid_write_en and pc_write_en are 0.
- R5: A branch in decode with no stall raises pc_redirect, with pc_target equal to the decode-stage branch target (predict taken). While stalled, no prediction redirect is made.
- R6: A branch in execute whose condition is false, and whose target differs from its address plus 8, raises pc_redirect with pc_target equal to that address plus 8. It also raises ifid_flush. The PC addition wraps at the PC width.
- R7: A taken branch in execute, or a not-taken one whose target equals its address plus 8, raises no flush and no correction.
- R8: A correction from execute takes PC priority over a decode prediction and over a stall. ifid_flush is never raised while stall is, so the frozen delay slot is never squashed.
- R9: With no hazard and no branch, every control is idle: both selects are 2'b00, stall, idex_bubble, pc_redirect and ifid_flush are 0, and the two write enables are 1.
- R10: A load to register 0, a register match on an unused decode source, or a non-load in execute causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst | input | 1 | Synchronous active-high reset for the checks |
| id_rs1 | input | REG_AW | Decode-stage first source register |
| id_rs2 | input | REG_AW | Decode-stage second source register |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| id_is_branch | input | 1 | Decode holds a conditional branch |
| id_br_target | input | PC_W | Branch target computed in decode |
| ex_rs1 | input | REG_AW | Execute-stage first source register |
| ex_rs2 | input | REG_AW | Execute-stage second source register |
| ex_rd | input | REG_AW | Execute-stage destination register |
| ex_mem_read | input | 1 | Execute holds a load |
| ex_is_branch | input | 1 | Execute holds a conditional branch |
| ex_br_taken | input | 1 | Branch condition evaluated in execute |
| ex_pc | input | PC_W | Address of the execute-stage instruction |
| ex_br_target | input | PC_W | Target of the execute-stage branch |
| mem_rd | input | REG_AW | Memory-stage destination register |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | REG_AW | Writeback-stage destination register |
| wb_reg_write | input | 1 | Writeback-stage instruction writes a register |
| fwd_a | output | 2 | Operand A source: 00 file, 01 writeback, 10 memory |
| fwd_b | output | 2 | Operand B source, same encoding |
| stall | output | 1 | Load-use hazard present |
| idex_bubble | output | 1 | Clear all controls entering execute |
| ifid_write_en | output | 1 | Load enable of the fetch/decode register |
| pc_write_en | output | 1 | PC update enable |
| pc_redirect | output | 1 | Load the PC from pc_target |
| pc_target | output | PC_W | Redirect address |
| ifid_flush | output | 1 | Squash the instruction entering decode |

## Verification
The bypass selects are swept over every pairing of source, memory destination, writeback destination and both write enables on a four-register build. This separates memory-over-writeback priority, the register-0 exclusion and the idle case. A second sweep crosses the load destination with both decode sources and their use flags, with and without a branch in decode. It tells true load-use stalls apart from matches on unused sources or register 0, and checks that prediction is suppressed while stalled. Branch resolution is tried at several addresses, including one where the fall-through wraps, with targets equal to and different from address plus 8. A short loop trace then replays a load, a branch on the loaded value, and a delay slot, taken on the first pass and not taken on the second.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  // Bytes from a branch to the first instruction after its delay slot.
  localparam int unsigned SLOT_SKIP_BYTES = 8;
  // Operands read by the execute stage.
  localparam int unsigned NUM_OPERANDS = 2;
endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_we,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  output logic [1:0]        sel
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic src_live;
  logic mem_hit;
  logic wb_hit;

  always_comb begin
    src_live = (src != ZERO_REG);
    mem_hit  = src_live && mem_we && (mem_rd == src);
    wb_hit   = src_live && wb_we && (wb_rd == src);
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  // R1: the youngest producer wins
  a_r1_mem_first: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_rd == src && src != '0) |-> sel == 2'b10);
  // R2: writeback used only without a memory-stage match
  a_r2_wb_second: assert property (@(posedge clk) disable iff (rst)
    (!(mem_we && mem_rd == src) && wb_we && wb_rd == src && src != '0) |-> sel == 2'b01);
  // R3: register zero reads the file
  a_r3_zero_src: assert property (@(posedge clk) disable iff (rst)
    (src == '0) |-> sel == 2'b00);
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned NSRC   = NUM_OPERANDS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NSRC-1:0][REG_AW-1:0] id_src,
  input  logic [NSRC-1:0]            id_use,
  input  logic [REG_AW-1:0]          ex_rd,
  input  logic                       ex_mem_read,
  output logic                       hazard
);
  logic [NSRC-1:0] hit;
  logic            load_live;

  assign load_live = ex_mem_read && (ex_rd != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = load_live && id_use[g] && (id_src[g] == ex_rd);
  end

  assign hazard = |hit;

  // R10: no load, or load to register zero, never stalls
  a_r10_no_load_no_stall: assert property (@(posedge clk) disable iff (rst)
    (!ex_mem_read || ex_rd == '0) |-> !hazard);
  // R10: sources not read never stall
  a_r10_unused_src: assert property (@(posedge clk) disable iff (rst)
    (id_use == '0) |-> !hazard);
endmodule

// File: rtl/hz_branch_ctl.sv
module hz_branch_ctl
  import hz_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            id_is_branch,
  input  logic [PC_W-1:0] id_target,
  input  logic            ex_is_branch,
  input  logic            ex_taken,
  input  logic [PC_W-1:0] ex_pc,
  input  logic [PC_W-1:0] ex_target,
  input  logic            stall,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_target,
  output logic            pc_we,
  output logic            flush
);
  localparam logic [PC_W-1:0] SKIP = PC_W'(SLOT_SKIP_BYTES);

  logic [PC_W-1:0] fall_thru;
  logic            mispredict;
  logic            predict;

  always_comb begin
    fall_thru  = ex_pc + SKIP;
    mispredict = ex_is_branch && !ex_taken && (ex_target != fall_thru);
    predict    = id_is_branch && !stall;
    pc_load    = mispredict || predict;
    pc_target  = mispredict ? fall_thru : id_target;
    pc_we      = !stall || mispredict;
    flush      = mispredict && !stall;
  end

  // R6: a wrong guess repairs to the instruction after the slot
  a_r6_repair_addr: assert property (@(posedge clk) disable iff (rst)
    (ex_is_branch && !ex_taken && ex_target != ex_pc + SKIP)
      |-> (pc_load && pc_target == ex_pc + SKIP));
  // R7: a taken branch never squashes
  a_r7_taken_quiet: assert property (@(posedge clk) disable iff (rst)
    (ex_is_branch && ex_taken) |-> !flush);
  // R5: prediction loads the decode target
  a_r5_predict: assert property (@(posedge clk) disable iff (rst)
    (id_is_branch && !stall && !ex_is_branch) |-> (pc_load && pc_target == id_target));
endmodule

// File: rtl/hz_ctl_top.sv
module hz_ctl_top
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_use_rs1,
  input  logic              id_use_rs2,
  input  logic              id_is_branch,
  input  logic [PC_W-1:0]   id_br_target,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_mem_read,
  input  logic              ex_is_branch,
  input  logic              ex_br_taken,
  input  logic [PC_W-1:0]   ex_pc,
  input  logic [PC_W-1:0]   ex_br_target,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_reg_write,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_reg_write,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              stall,
  output logic              idex_bubble,
  output logic              ifid_write_en,
  output logic              pc_write_en,
  output logic              pc_redirect,
  output logic [PC_W-1:0]   pc_target,
  output logic              ifid_flush
);
  localparam int unsigned NOPS = NUM_OPERANDS;

  logic [NOPS-1:0][REG_AW-1:0] ex_src;
  logic [NOPS-1:0][1:0]        ex_sel;
  logic [NOPS-1:0][REG_AW-1:0] id_src;
  logic [NOPS-1:0]             id_use;
  logic                        hazard;

  assign ex_src = {ex_rs2, ex_rs1};
  assign id_src = {id_rs2, id_rs1};
  assign id_use = {id_use_rs2, id_use_rs1};

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    hz_fwd_unit #(.REG_AW(REG_AW)) u_fwd (
      .clk    (clk),
      .rst    (rst),
      .src    (ex_src[g]),
      .mem_rd (mem_rd),
      .mem_we (mem_reg_write),
      .wb_rd  (wb_rd),
      .wb_we  (wb_reg_write),
      .sel    (ex_sel[g])
    );
  end

  assign fwd_a = ex_sel[0];
  assign fwd_b = ex_sel[1];

  hz_load_use #(.REG_AW(REG_AW), .NSRC(NOPS)) u_lu (
    .clk         (clk),
    .rst         (rst),
    .id_src      (id_src),
    .id_use      (id_use),
    .ex_rd       (ex_rd),
    .ex_mem_read (ex_mem_read),
    .hazard      (hazard)
  );

  assign stall         = hazard;
  assign idex_bubble   = hazard;
  assign ifid_write_en = !hazard;

  hz_branch_ctl #(.PC_W(PC_W)) u_br (
    .clk          (clk),
    .rst          (rst),
    .id_is_branch (id_is_branch),
    .id_target    (id_br_target),
    .ex_is_branch (ex_is_branch),
    .ex_taken     (ex_br_taken),
    .ex_pc        (ex_pc),
    .ex_target    (ex_br_target),
    .stall        (hazard),
    .pc_load      (pc_redirect),
    .pc_target    (pc_target),
    .pc_we        (pc_write_en),
    .flush        (ifid_flush)
  );

  // R4: a stall bubbles execute and freezes decode
  a_r4_stall_freeze: assert property (@(posedge clk) disable iff (rst)
    stall |-> (idex_bubble && !ifid_write_en));
  // R8: the frozen delay slot is never squashed
  a_r8_no_flush_in_stall: assert property (@(posedge clk) disable iff (rst)
    ifid_flush |-> !stall);
  // R8: the PC moves during a stall only for a repair
  a_r8_pc_frozen: assert property (@(posedge clk) disable iff (rst)
    (stall && !ifid_flush && pc_write_en) |-> (ex_is_branch && !ex_br_taken));
endmodule

// File: tb/sim_hz_ctl_top.sv
`timescale 1ns/1ps
module sim_hz_ctl_top;
  localparam int unsigned AW = 2;
  localparam int unsigned PW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_use_rs1, id_use_rs2, id_is_branch, ex_mem_read, ex_is_branch, ex_br_taken;
  logic mem_reg_write, wb_reg_write;
  logic [PW-1:0] id_br_target, ex_pc, ex_br_target;
  logic [1:0] fwd_a, fwd_b;
  logic stall, idex_bubble, ifid_write_en, pc_write_en, pc_redirect, ifid_flush;
  logic [PW-1:0] pc_target;

  hz_ctl_top #(.REG_AW(AW), .PC_W(PW)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    id_rs1 = '0; id_rs2 = '0; id_use_rs1 = 0; id_use_rs2 = 0; id_is_branch = 0;
    id_br_target = 32'h0000_0400;
    ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; ex_mem_read = 0; ex_is_branch = 0; ex_br_taken = 0;
    ex_pc = 32'h0000_0100; ex_br_target = 32'h0000_0200;
    mem_rd = '0; mem_reg_write = 0; wb_rd = '0; wb_reg_write = 0;
  endtask

  function automatic logic [1:0] exp_sel(int s, int m, int mw, int w, int ww);
    if (s == 0) return 2'b00;
    if (mw != 0 && m == s) return 2'b10;
    if (ww != 0 && w == s) return 2'b01;
    return 2'b00;
  endfunction

  initial begin
    #1_600_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: idle controls
    chk("R9 fwd_a", fwd_a, 2'b00);
    chk("R9 fwd_b", fwd_b, 2'b00);
    chk("R9 stall", stall, 0);
    chk("R9 redirect", pc_redirect, 0);
    chk("R9 flush", ifid_flush, 0);
    chk("R9 pc_we", pc_write_en, 1);
    chk("R9 ifid_we", ifid_write_en, 1);

    // Bypass sweep: R1 R2 R3
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 4; w++)
          for (int e = 0; e < 4; e++) begin
            idle();
            ex_rs1 = AW'(s); ex_rs2 = AW'(3 - s);
            mem_rd = AW'(m); wb_rd = AW'(w);
            mem_reg_write = e[0]; wb_reg_write = e[1];
            @(negedge clk);
            chk((s == 0) ? "R3 fwd_a" : "R1/R2 fwd_a", fwd_a, exp_sel(s, m, e & 1, w, e >> 1));
            chk((s == 3) ? "R3 fwd_b" : "R1/R2 fwd_b", fwd_b, exp_sel(3 - s, m, e & 1, w, e >> 1));
          end

    // Load-use sweep: R4 R5 R10
    for (int d = 0; d < 4; d++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int u = 0; u < 4; u++)
            for (int k = 0; k < 4; k++) begin
              logic hz;
              idle();
              ex_rd = AW'(d); id_rs1 = AW'(a); id_rs2 = AW'(b);
              id_use_rs1 = u[0]; id_use_rs2 = u[1];
              ex_mem_read = k[0]; id_is_branch = k[1];
              hz = k[0] && d != 0 && ((u[0] && a == d) || (u[1] && b == d));
              @(negedge clk);
              chk(hz ? "R4 stall" : "R10 stall", stall, hz);
              chk("R4 bubble", idex_bubble, hz);
              chk("R4 ifid_we", ifid_write_en, !hz);
              chk("R4 pc_we", pc_write_en, !hz);
              chk("R5 redirect", pc_redirect, k[1] && !hz);
              if (k[1] && !hz) chk("R5 target", pc_target, 32'h0000_0400);
            end

    // Branch resolution sweep: R6 R7 R8
    for (int p = 0; p < 3; p++)
      for (int t = 0; t < 3; t++)
        for (int c = 0; c < 8; c++) begin
          logic [PW-1:0] pcv, tg, ft;
          logic misp, hz;
          idle();
          pcv = (p == 0) ? 32'h0 : (p == 1) ? 32'h0000_1000 : 32'hFFFF_FFFC;
          ft = pcv + 32'd8;
          tg = (t == 0) ? ft : (t == 1) ? pcv - 32'd16 : pcv + 32'h40;
          ex_is_branch = 1; ex_pc = pcv; ex_br_target = tg;
          ex_br_taken = c[0]; id_is_branch = c[1];
          if (c[2]) begin
            ex_mem_read = 1; ex_rd = 2'd1; id_rs1 = 2'd1; id_use_rs1 = 1;
          end
          misp = !c[0] && tg != ft;
          hz = c[2];
          @(negedge clk);
          chk(misp ? "R6 flush" : "R7 flush", ifid_flush, misp && !hz);
          chk(misp ? "R6 redirect" : "R7 redirect", pc_redirect, misp || (c[1] && !hz));
          if (misp) chk("R6 target", pc_target, ft);
          chk("R8 pc_we", pc_write_en, !hz || misp);
          if (hz) chk("R8 no flush in stall", ifid_flush, 0);
        end

    // Loop trace: load r2; branch on r2; slot op; taken then not taken
    idle();
    ex_mem_read = 1; ex_rd = 2'd2;
    id_is_branch = 1; id_rs1 = 2'd2; id_use_rs1 = 1; id_br_target = 32'h0000_0100;
    @(negedge clk);
    chk("R4 trace branch-on-load stall", stall, 1);
    chk("R5 trace no prediction in stall", pc_redirect, 0);
    idle();
    mem_rd = 2'd2; mem_reg_write = 1;
    id_is_branch = 1; id_rs1 = 2'd2; id_use_rs1 = 1; id_br_target = 32'h0000_0100;
    @(negedge clk);
    chk("R5 trace prediction", pc_redirect, 1);
    chk("R5 trace target", pc_target, 32'h0000_0100);
    idle();
    wb_rd = 2'd2; wb_reg_write = 1;
    ex_is_branch = 1; ex_rs1 = 2'd2; ex_pc = 32'h0000_0104;
    ex_br_target = 32'h0000_0100; ex_br_taken = 1;
    id_rs1 = 2'd2; id_rs2 = 2'd3; id_use_rs1 = 1; id_use_rs2 = 1;
    @(negedge clk);
    chk("R2 trace branch operand", fwd_a, 2'b01);
    chk("R7 trace taken pass", ifid_flush, 0);
    ex_br_taken = 0;
    @(negedge clk);
    chk("R6 trace not-taken flush", ifid_flush, 1);
    chk("R6 trace fall-through", pc_target, 32'h0000_010C);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule